// File: doc/BRIEF.md
# Fixed-Priority Interrupt Arbiter

This block gathers the interrupt requests of up to 32 vector entries and hands one of them at a time to the exception entry sequencer. Each entry has a pending flag, held inside the block, and an enable bit, held in a separate software-written enable register. Among the entries that are pending and enabled, the one with the highest vector number wins. Which request arrived first plays no part in the choice. A global enable input masks every maskable entry together. Entry 30 is non-maskable: it ignores the global enable but still obeys its own enable bit. Entry 31 belongs to reset, and this block never requests it.

The winner is presented on a registered valid/index pair. The pair holds steady until the sequencer acknowledges it. Taking a request never touches the enable register. For a single-source entry, the acknowledge clears that entry's pending flag. A multi-source entry's flag simply mirrors the level its peripheral drives, and the acknowledge leaves it alone. The peripheral's service routine drops that level once every sub-source has been handled.

Top module: `irq_prio_arbiter`

## Requirements
- R1: When several entries are candidates at the moment of selection, the presented index is the highest candidate number (for example 9 is chosen over 6). A candidate is pending, enabled, not entry 31, and either entry 30 or globally enabled.
- R2: Selection ignores arrival order. If entry 6 becomes pending before entry 9 while both are masked, and both are then unmasked, entry 9 is presented first.
- R3: Enable register bit i gates entry i. A pending entry whose enable bit is 0 is never presented.
- R4: The enable register changes only on a configuration write (it takes the write data whole). An acknowledge never alters it, and its value is visible on the read-back port.
- R5: With the global enable at 0, no entry other than entry 30 is presented.
- R6: Entry 30 is presented while the global enable is 0, provided its enable bit is 1. With its enable bit at 0 it is not presented.
- R7: Entry 31 is never presented, even when it is pending and enabled.
- R8: For a single-source entry, a 1 on its request input sets its flag, and the acknowledge of that entry clears it (a set in the same cycle wins). For a multi-source entry (by default entries 2 and 3), the flag follows the request input level one cycle later, and the acknowledge has no effect on it.
- R9: Once the valid output is high, the valid output and the index stay unchanged until the acknowledge, even if a higher-numbered request appears.
- R10: After reset the valid output is 0, all flags are 0 and the enable register reads 0.
- R11: An acknowledge with the valid output high drops the valid output at that clock edge. The next winner, if any, is presented at the following edge. A request becomes presentable at the edge after its flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Per-entry request: set pulse for single-source entries, level for multi-source entries |
| gie | input | 1 | Global enable for maskable entries |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 32 | Enable register write data |
| cfg_rdata | output | 32 | Enable register read-back |
| req_valid | output | 1 | A request is presented to the sequencer |
| req_idx | output | 5 | Vector index of the presented request |
| req_ack | input | 1 | Sequencer takes the presented request |

## Verification
Directed patterns set a low entry before a higher one while both are masked, to separate priority by number from priority by arrival order. They also raise entry 30 and an ordinary entry with the global enable off, which separates non-maskable handling from ordinary masking. Further cases make entry 31 pending alone, and raise a higher entry while a lower one is held, to catch a grant that changes before its acknowledge. A held multi-source level is acknowledged and must come back, while a single-source flag must not. Random flag, enable, global-enable and acknowledge patterns are then compared cycle by cycle against a bench model. This exposes wrong masking combinations and wrong timing around acknowledge edges.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int IRQ_NUM_DEFAULT = 32;
  localparam logic [31:0] IRQ_MULTI_DEFAULT = 32'h0000_000C;

  function automatic int idx_width(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM = 32,
  parameter logic [NUM-1:0] MULTI = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] src_in,
  input  logic [NUM-1:0] ack_clr,
  output logic [NUM-1:0] flags
);
  for (genvar i = 0; i < NUM; i++) begin : g_flag
    if (MULTI[i]) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) flags[i] <= 1'b0;
        else     flags[i] <= src_in[i];
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)             flags[i] <= 1'b0;
        else if (src_in[i])  flags[i] <= 1'b1;
        else if (ack_clr[i]) flags[i] <= 1'b0;
      end
      // R8: acknowledge clears a single-source flag when no new set arrives
      assert_single_clear_R8: assert property (@(posedge clk) disable iff (rst)
        ack_clr[i] && !src_in[i] |=> !flags[i]);
    end
  end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs #(
  parameter int NUM = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [NUM-1:0] wr_data,
  output logic [NUM-1:0] enables
);
  always_ff @(posedge clk) begin
    if (rst)        enables <= '0;
    else if (wr_en) enables <= wr_data;
  end

  // R4: without a write the enable register holds
  assert_enable_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(enables));
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int NUM = 32,
  parameter int IDX_W = 5,
  parameter int RESET_IDX = 31,
  parameter int NMI_IDX = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM-1:0]   flags,
  input  logic [NUM-1:0]   enables,
  input  logic             gie,
  output logic             any_cand,
  output logic [IDX_W-1:0] win_idx
);
  logic [NUM-1:0] cand;

  for (genvar i = 0; i < NUM; i++) begin : g_mask
    if (i == RESET_IDX) begin : g_rst
      assign cand[i] = 1'b0;
    end else if (i == NMI_IDX) begin : g_nmi
      assign cand[i] = flags[i] & enables[i];
    end else begin : g_mask_std
      assign cand[i] = flags[i] & enables[i] & gie;
    end
  end

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM; i++) begin
      if (cand[i]) win_idx = IDX_W'(i);
    end
  end

  assign any_cand = |cand;

  // R1: the winner is a candidate and no higher entry is
  assert_highest_wins_R1: assert property (@(posedge clk) disable iff (rst)
    any_cand |-> cand[win_idx] && ((cand >> win_idx) == NUM'(1)));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM = IRQ_NUM_DEFAULT,
  parameter logic [NUM-1:0] MULTI = IRQ_MULTI_DEFAULT[NUM-1:0],
  parameter int RESET_IDX = NUM - 1,
  parameter int NMI_IDX = NUM - 2,
  localparam int IDX_W = idx_width(NUM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM-1:0]   irq_in,
  input  logic             gie,
  input  logic             cfg_we,
  input  logic [NUM-1:0]   cfg_wdata,
  output logic [NUM-1:0]   cfg_rdata,
  output logic             req_valid,
  output logic [IDX_W-1:0] req_idx,
  input  logic             req_ack
);
  logic [NUM-1:0]   flags;
  logic [NUM-1:0]   enables;
  logic [NUM-1:0]   ack_clr;
  logic             any_cand;
  logic [IDX_W-1:0] win_idx;
  logic             take;

  assign take = req_valid & req_ack;

  for (genvar i = 0; i < NUM; i++) begin : g_clr
    assign ack_clr[i] = take && (req_idx == IDX_W'(i));
  end

  irq_flag_bank #(.NUM(NUM), .MULTI(MULTI)) u_flags (
    .clk(clk), .rst(rst), .src_in(irq_in), .ack_clr(ack_clr), .flags(flags)
  );

  irq_enable_regs #(.NUM(NUM)) u_en (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_data(cfg_wdata), .enables(enables)
  );

  irq_prio_select #(.NUM(NUM), .IDX_W(IDX_W), .RESET_IDX(RESET_IDX), .NMI_IDX(NMI_IDX)) u_sel (
    .clk(clk), .rst(rst), .flags(flags), .enables(enables), .gie(gie),
    .any_cand(any_cand), .win_idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_idx   <= '0;
    end else if (take) begin
      req_valid <= 1'b0;
    end else if (!req_valid && any_cand) begin
      req_valid <= 1'b1;
      req_idx   <= win_idx;
    end
  end

  assign cfg_rdata = enables;

  // R9: presented request holds until acknowledged
  assert_grant_hold_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ack |=> req_valid && $stable(req_idx));
  // R11: acknowledge drops valid at the next edge
  assert_ack_drop_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ack |=> !req_valid);
  // R7: reset entry never presented
  assert_no_reset_idx_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_idx != IDX_W'(RESET_IDX));
  // R5: with global enable off only the non-maskable entry is newly presented
  assert_gie_mask_R5: assert property (@(posedge clk) disable iff (rst)
    !req_valid && !gie |=> !req_valid || req_idx == IDX_W'(NMI_IDX));
endmodule

// File: tb/tb_irq_prio_arbiter.sv
module tb_irq_prio_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        gie = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid;
  logic [4:0]  req_idx;
  logic        req_ack = 1'b0;

  localparam logic [31:0] MULTI_M = 32'h0000_000C;
  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0] m_flag, m_en;
  logic        m_valid;
  logic [4:0]  m_idx;

  irq_prio_arbiter dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .gie(gie), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_idx(req_idx), .req_ack(req_ack)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] cand_of(logic [31:0] f, logic [31:0] e, logic g);
    logic [31:0] c;
    c = f & e & (g ? 32'hFFFF_FFFF : 32'h4000_0000);
    c[31] = 1'b0;
    return c;
  endfunction

  function automatic logic [4:0] top_of(logic [31:0] c);
    logic [4:0] r = '0;
    for (int i = 0; i < 32; i++) if (c[i]) r = 5'(i);
    return r;
  endfunction

  // reference model built from the requirements
  always @(posedge clk) begin
    logic [31:0] c, nf;
    logic take;
    if (rst) begin
      m_flag = '0; m_en = '0; m_valid = 1'b0; m_idx = '0;
    end else begin
      c = cand_of(m_flag, m_en, gie);
      take = m_valid && req_ack;
      for (int i = 0; i < 32; i++) begin
        if (MULTI_M[i]) nf[i] = irq_in[i];
        else if (irq_in[i]) nf[i] = 1'b1;
        else if (take && m_idx == 5'(i)) nf[i] = 1'b0;
        else nf[i] = m_flag[i];
      end
      if (take) m_valid = 1'b0;
      else if (!m_valid && |c) begin m_valid = 1'b1; m_idx = top_of(c); end
      m_flag = nf;
      if (cfg_we) m_en = cfg_wdata;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R11 watchdog: cycles=%0d expected<=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_en(logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v; tick(); cfg_we = 1'b0;
  endtask

  task automatic pulse(int i);
    irq_in[i] = 1'b1; tick(); irq_in[i] = 1'b0;
  endtask

  task automatic ack1();
    req_ack = 1'b1; tick(); req_ack = 1'b0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    tick();
    check("R10 valid after reset", 32'(req_valid), 0);
    check("R10 enables after reset", cfg_rdata, 0);

    // R2 / R1: 6 then 9 while masked, then unmask
    write_en(32'hFFFF_FFFF);
    gie = 1'b0;
    pulse(6); pulse(9); tick();
    check("R5 masked by gie", 32'(req_valid), 0);
    gie = 1'b1; tick();
    check("R2 arrival ignored valid", 32'(req_valid), 1);
    check("R1 R2 higher entry first", 32'(req_idx), 9);
    ack1();
    check("R11 valid drops on ack", 32'(req_valid), 0);
    tick();
    check("R11 next winner valid", 32'(req_valid), 1);
    check("R11 next winner index", 32'(req_idx), 6);
    check("R4 ack leaves enables", cfg_rdata, 32'hFFFF_FFFF);
    ack1(); tick();
    check("R8 single flag cleared by ack", 32'(req_valid), 0);

    // R6 non-maskable entry
    gie = 1'b0;
    irq_in[30] = 1'b1; irq_in[5] = 1'b1; tick(); irq_in = '0; tick();
    check("R6 nmi served with gie off", 32'(req_valid), 1);
    check("R6 nmi index", 32'(req_idx), 30);
    ack1(); tick();
    check("R5 entry 5 held off by gie", 32'(req_valid), 0);
    write_en(32'hBFFF_FFFF);
    pulse(30); tick(); tick();
    check("R6 nmi obeys own enable", 32'(req_valid), 0);
    gie = 1'b1; tick();
    check("R3 disabled 30 skipped, 5 chosen", 32'(req_idx), 5);
    ack1(); tick();
    check("R3 nothing else", 32'(req_valid), 0);

    // R3 enable bit gates entry
    write_en(32'h0000_0000);
    pulse(12); tick(); tick();
    check("R3 disabled entry not presented", 32'(req_valid), 0);
    write_en(32'h0000_1000); tick();
    check("R3 enabled entry presented", 32'(req_idx), 12);
    ack1(); tick();

    // R7 reset entry
    write_en(32'hBFFF_FFFF);
    pulse(31); tick(); tick();
    check("R7 entry 31 never presented", 32'(req_valid), 0);

    // R9 hold under higher request
    pulse(4); tick();
    check("R9 low entry presented", 32'(req_idx), 4);
    pulse(20); tick(); tick();
    check("R9 valid held", 32'(req_valid), 1);
    check("R9 index held", 32'(req_idx), 4);
    ack1(); tick();
    check("R9 higher follows", 32'(req_idx), 20);
    ack1(); tick();
    check("R8 single-source not re-presented", 32'(req_valid), 0);

    // R8 multi-source level
    irq_in[3] = 1'b1; tick(); tick();
    check("R8 multi presented", 32'(req_idx), 3);
    ack1(); tick();
    check("R8 multi survives ack valid", 32'(req_valid), 1);
    check("R8 multi survives ack index", 32'(req_idx), 3);
    irq_in[3] = 1'b0; ack1(); tick(); tick();
    check("R8 multi gone after level drops", 32'(req_valid), 0);

    // random phase against the model
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = '0;
      if ($urandom_range(0, 3) == 0) r[$urandom_range(0, 31)] = 1'b1;
      if ($urandom_range(0, 7) == 0) r[$urandom_range(0, 31)] = 1'b1;
      r[3:2] = irq_in[3:2];
      if ($urandom_range(0, 9) == 0) r[3:2] = 2'($urandom);
      irq_in = r;
      gie = ($urandom_range(0, 4) != 0);
      cfg_we = ($urandom_range(0, 40) == 0);
      cfg_wdata = $urandom;
      req_ack = req_valid && ($urandom_range(0, 2) == 0);
      tick();
      check("R1 R9 random valid", 32'(req_valid), 32'(m_valid));
      if (m_valid) check("R1 R5 random index", 32'(req_idx), 32'(m_idx));
      check("R4 random enables", cfg_rdata, m_en);
    end
    irq_in = '0; cfg_we = 1'b0; req_ack = 1'b0;
    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule